// File: doc/BRIEF.md
# DMA Stream Completion and Abort Interrupt Aggregator

This block keeps the interrupt state for a group of four DMA streams. Each stream engine sends the block a one-cycle pulse when the stream's last transfer has finished, and another pulse when a bus slave's error response has aborted the stream. Each pulse latches a sticky flag. There is one completion flag and one abort flag per stream. The flags stay set until software clears them.

Software uses a small synchronous register port. It can read the raw flags, the masked flags and the run state of each stream. It can program a separate enable bit for every flag and clear flags by writing ones. All enabled flags are ORed together into one registered interrupt line. The stream engines and the bus adapter are outside this block. They appear only as the pulse and level inputs.

Top module: `dma_irq_agg`

## Requirements
- R1: A pulse on `done_evt[i]` sets completion flag i at that clock edge. The flag then reads as 1 in bit i at address 0 and stays set until it is cleared.
- R2: A pulse on `err_evt[i]` sets abort flag i at that clock edge. The flag then reads as 1 in bit i at address 1 and stays set until it is cleared.
- R3: A write to address 0 or 1 clears each flag whose `wdata` bit is 1. Flags whose `wdata` bit is 0 are not changed. Flags of other streams are not changed.
- R4: If a set pulse and a write-one clear reach the same flag in the same cycle, the flag ends up set.
- R5: Address 2 holds the completion enable bits and address 3 holds the abort enable bits. Both can be read and written, and both reset to 0. An enable bit gates only the flag's interrupt contribution. A raw flag still latches and can be read while its enable bit is 0.
- R6: Address 4 reads the completion flags ANDed with their enable bits. Address 5 reads the abort flags ANDed with their enable bits.
- R7: `irq` is a register. It is 1 exactly one cycle after any flag is both set and enabled. It falls one cycle after the last enabled flag clears or is disabled.
- R8: Address 6 reads `active_in` as it was sampled at the previous clock edge.
- R9: Synchronous reset clears every flag, enable bit, the mirrored run state and `irq`. Address 7 reads 0. Writes to addresses 4 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_evt | input | 4 | Per-stream last-transfer-finished pulses |
| err_evt | input | 4 | Per-stream aborted-by-slave-error pulses |
| active_in | input | 4 | Per-stream running levels from the engines |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both read and write |
| wdata | input | 4 | Write data, one bit per stream |
| rdata | output | 4 | Read data for `addr`, combinational from the registered state |
| irq | output | 1 | Combined interrupt line |

## Verification
A pulse or a write at edge k changes the flags, the enables and the mirrored run state at that edge. Read data for any address therefore shows the change in the cycle after edge k. `irq` is formed from the state that existed before edge k and lags that state by one more edge. The bench drives at the falling edge and compares `irq` at the next falling edge against a value its model saved one cycle earlier. Read data is compared 1 ns after the inputs are driven, against the model's state before the coming edge. Each comparison therefore lands on the exact cycle in which that result becomes due.

// File: rtl/dma_irq_agg_pkg.sv
package dma_irq_agg_pkg;

    localparam int NUM_STREAMS = 4;
    localparam int ADDR_W      = 3;

    typedef logic [NUM_STREAMS-1:0] stream_vec_t;

    typedef enum logic [ADDR_W-1:0] {
        RA_DONE_RAW  = 3'd0,
        RA_ERR_RAW   = 3'd1,
        RA_DONE_EN   = 3'd2,
        RA_ERR_EN    = 3'd3,
        RA_DONE_MSK  = 3'd4,
        RA_ERR_MSK   = 3'd5,
        RA_ACTIVE    = 3'd6,
        RA_RESERVED  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        stream_vec_t done;
        stream_vec_t err;
    } flag_pair_t;

    // Set has priority over a write-one clear.
    function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction

endpackage

// File: rtl/sticky_flag_bank.sv
module sticky_flag_bank
    import dma_irq_agg_pkg::*;
#(
    parameter int WIDTH = NUM_STREAMS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] flag_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_flag
        logic q;
        always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= sticky_next(q, set_i[i], clr_i[i]);
        end
        assign flag_o[i] = q;
    end
endmodule

// File: rtl/agg_regs.sv
module agg_regs
    import dma_irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  stream_vec_t       wdata,
    input  flag_pair_t        flags,
    input  stream_vec_t       active_q,
    output flag_pair_t        clr,
    output flag_pair_t        enables,
    output stream_vec_t       rdata
);
    reg_addr_e sel;
    assign sel = reg_addr_e'(addr);

    always_comb begin
        clr.done = (wr_en && sel == RA_DONE_RAW) ? wdata : '0;
        clr.err  = (wr_en && sel == RA_ERR_RAW)  ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enables <= '0;
        end else if (wr_en) begin
            if (sel == RA_DONE_EN) enables.done <= wdata;
            if (sel == RA_ERR_EN)  enables.err  <= wdata;
        end
    end

    always_comb begin
        unique case (sel)
            RA_DONE_RAW: rdata = flags.done;
            RA_ERR_RAW:  rdata = flags.err;
            RA_DONE_EN:  rdata = enables.done;
            RA_ERR_EN:   rdata = enables.err;
            RA_DONE_MSK: rdata = flags.done & enables.done;
            RA_ERR_MSK:  rdata = flags.err & enables.err;
            RA_ACTIVE:   rdata = active_q;
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
    import dma_irq_agg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  done_evt,
    input  logic [3:0]  err_evt,
    input  logic [3:0]  active_in,
    input  logic        wr_en,
    input  logic [2:0]  addr,
    input  logic [3:0]  wdata,
    output logic [3:0]  rdata,
    output logic        irq
);
    flag_pair_t  flags;
    flag_pair_t  clr;
    flag_pair_t  enables;
    stream_vec_t active_q;
    logic        irq_q;

    sticky_flag_bank #(.WIDTH(NUM_STREAMS)) u_done_bank (
        .clk(clk), .rst(rst), .set_i(done_evt), .clr_i(clr.done), .flag_o(flags.done)
    );

    sticky_flag_bank #(.WIDTH(NUM_STREAMS)) u_err_bank (
        .clk(clk), .rst(rst), .set_i(err_evt), .clr_i(clr.err), .flag_o(flags.err)
    );

    agg_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .flags(flags), .active_q(active_q), .clr(clr), .enables(enables), .rdata(rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            active_q <= active_in;
            irq_q    <= |(flags & enables);
        end
    end

    assign irq = irq_q;
endmodule

// File: rtl/dma_irq_agg_chk.sv
module dma_irq_agg_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] done_evt,
    input logic [3:0] err_evt,
    input logic [3:0] active_in,
    input logic       wr_en,
    input logic [2:0] addr,
    input logic [3:0] wdata,
    input logic [3:0] rdata,
    input logic       irq,
    input logic [7:0] flags,
    input logic [7:0] enables
);
    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= rst | armed;

    // flags packs {done, err}; enables likewise
    p_done_set_r1: assert property (@(posedge clk) disable iff (rst || !armed)
        (done_evt != 4'd0) |=> ((flags[7:4] & $past(done_evt)) == $past(done_evt)));

    p_err_set_r2: assert property (@(posedge clk) disable iff (rst || !armed)
        (err_evt != 4'd0) |=> ((flags[3:0] & $past(err_evt)) == $past(err_evt)));

    p_w1c_r3: assert property (@(posedge clk) disable iff (rst || !armed)
        (wr_en && addr == 3'd0) |=> ((flags[7:4] & $past(wdata & ~done_evt)) == 4'd0));

    p_set_wins_r4: assert property (@(posedge clk) disable iff (rst || !armed)
        (wr_en && addr == 3'd1 && (err_evt & wdata) != 4'd0)
        |=> ((flags[3:0] & $past(err_evt & wdata)) == $past(err_evt & wdata)));

    p_irq_r7: assert property (@(posedge clk) disable iff (rst || !armed)
        1'b1 |=> (irq == $past((flags & enables) != 8'd0)));

    p_active_r8: assert property (@(posedge clk) disable iff (rst || !armed)
        (addr == 3'd6 && !$rose(armed)) |-> (rdata == $past(active_in)));

    p_ro_write_r9: assert property (@(posedge clk) disable iff (rst || !armed)
        (wr_en && addr[2]) |=> $stable(enables));
endmodule

bind dma_irq_agg dma_irq_agg_chk u_chk (
    .clk(clk), .rst(rst), .done_evt(done_evt), .err_evt(err_evt),
    .active_in(active_in), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .flags(flags), .enables(enables)
);

// File: tb/sim_dma_irq_agg.sv
`timescale 1ns/1ps
module sim_dma_irq_agg;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] done_evt = '0, err_evt = '0, active_in = '0, wdata = '0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [3:0] rdata;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done_flag = 0;

    logic [3:0] md = '0, me = '0, mden = '0, meen = '0, mact = '0;
    logic       exp_irq = 1'b0;

    always #10 clk = ~clk;

    dma_irq_agg u0 (
        .clk(clk), .rst(rst), .done_evt(done_evt), .err_evt(err_evt),
        .active_in(active_in), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    function automatic logic [3:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return md;
            3'd1: return me;
            3'd2: return mden;
            3'd3: return meen;
            3'd4: return md & mden;
            3'd5: return me & meen;
            3'd6: return mact;
            default: return 4'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0: return "R1/R3/R4";
            3'd1: return "R2/R3/R4";
            3'd2, 3'd3: return "R5";
            3'd4, 3'd5: return "R6";
            3'd6: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic cycle(input logic we, input logic [2:0] a, input logic [3:0] wd,
                         input logic [3:0] de, input logic [3:0] ee, input logic [3:0] act);
        logic [3:0] cd, ce;
        logic nirq;
        // R7: registered interrupt line
        checks++;
        if (irq !== exp_irq) begin
            failures++;
            $display("FAIL R7 irq actual=%0b expected=%0b", irq, exp_irq);
        end
        wr_en = we; addr = a; wdata = wd; done_evt = de; err_evt = ee; active_in = act;
        #1;
        checks++;
        if (rdata !== exp_read(a)) begin
            failures++;
            $display("FAIL %s rdata addr=%0d actual=%h expected=%h", tag_of(a), a, rdata, exp_read(a));
        end
        @(posedge clk);
        nirq = |((md & mden) | (me & meen));
        cd = (we && a == 3'd0) ? wd : 4'd0;
        ce = (we && a == 3'd1) ? wd : 4'd0;
        md = (md & ~cd) | de;
        me = (me & ~ce) | ee;
        if (we && a == 3'd2) mden = wd;
        if (we && a == 3'd3) meen = wd;
        mact = act;
        exp_irq = nirq;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9: reset state, every address reads its reset value
        for (int a = 0; a < 8; a++) cycle(1'b0, 3'(a), 4'h0, 4'h0, 4'h0, 4'h0);
        // R5: masked-off completion still latches, no interrupt
        cycle(1'b0, 3'd0, 4'h0, 4'b0001, 4'h0, 4'h0);
        cycle(1'b0, 3'd0, 4'h0, 4'h0, 4'h0, 4'h0);
        cycle(1'b0, 3'd4, 4'h0, 4'h0, 4'h0, 4'h0);
        // R5/R7: enable it, interrupt follows
        cycle(1'b1, 3'd2, 4'b0001, 4'h0, 4'h0, 4'h0);
        cycle(1'b0, 3'd4, 4'h0, 4'h0, 4'h0, 4'h0);
        cycle(1'b0, 3'd0, 4'h0, 4'h0, 4'h0, 4'h0);
        // R4: set and clear together, set wins
        cycle(1'b1, 3'd0, 4'b0001, 4'b0001, 4'h0, 4'h0);
        cycle(1'b0, 3'd0, 4'h0, 4'h0, 4'h0, 4'h0);
        // R3/R7: clear, irq drops one cycle later
        cycle(1'b1, 3'd0, 4'b0001, 4'h0, 4'h0, 4'h0);
        cycle(1'b0, 3'd0, 4'h0, 4'h0, 4'h0, 4'h0);
        cycle(1'b0, 3'd0, 4'h0, 4'h0, 4'h0, 4'h0);
        // R2/R6: abort flag on stream 3 with enable
        cycle(1'b1, 3'd3, 4'b1000, 4'h0, 4'b1000, 4'b0110);
        cycle(1'b0, 3'd5, 4'h0, 4'h0, 4'h0, 4'b0110);
        cycle(1'b0, 3'd6, 4'h0, 4'h0, 4'h0, 4'h0);
        // R9: writes to read-only addresses ignored
        for (int a = 4; a < 8; a++) cycle(1'b1, 3'(a), 4'hF, 4'h0, 4'h0, 4'h0);
        for (int a = 0; a < 4; a++) cycle(1'b0, 3'(a), 4'h0, 4'h0, 4'h0, 4'h0);
        // random traffic across all requirements
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] de, ee;
            de = 4'($urandom & $urandom & $urandom);
            ee = 4'($urandom & $urandom & $urandom);
            cycle(1'($urandom), 3'($urandom), 4'($urandom), de, ee, 4'($urandom));
        end
        cycle(1'b0, 3'd0, 4'h0, 4'h0, 4'h0, 4'h0);
        finish_run();
    end
endmodule